// File: doc/BRIEF.md
# Scaler Settings Register Block with Commit Staging

This block keeps the run-time settings of a video scaler: the output field width, the output field height, and the read-bank selects for the horizontal and vertical coefficient stores. Software reaches it over a simple 32-bit register bus with write and read strobes, byte addresses and one cycle of read latency. Every settings write lands in a shadow copy. The scaler datapath only sees a second, active copy, which drives the block's outputs.

Shadow values are copied into the active set only at a field boundary, and only after software has written the commit register. The field boundary is a one-cycle start-of-field pulse. A status register reports two things: whether a field is in progress, taken from the field-active input, and whether staged changes are still waiting to be applied. Software can therefore change several settings at once and have them all take effect on the same field.

Top module: `scl_settings_ctrl`

## Requirements
- R1: After reset, the active outputs and the shadow readbacks hold the parameter defaults, and both status bits read 0.
- R2: Status bit 0 (offset 0x140) returns the level of field_active in the cycle the read strobe is sampled.
- R3: A write to any settings offset (0x148 width, 0x14C height, 0x150 horizontal bank, 0x154 vertical bank) sets status bit 1, the pending flag.
- R4: A settings read returns the last value written. Only the field's low bits are kept (DIM_W bits for width and height, BANK_W bits for banks), and every other bit reads 0.
- R5: Settings writes leave the active outputs unchanged until a boundary that follows a commit. The data written to commit (0x144) is ignored, and commit reads as 0.
- R6: On the first start-of-field pulse after a commit write, all four active outputs take the shadow values and the pending flag clears in the same cycle.
- R7: A commit write in the same cycle as a start-of-field pulse has no effect at that pulse. It applies at the next pulse.
- R8: A settings write made after a commit but before the boundary is part of the applied update. A settings write in the cycle of the applying pulse leaves the pending flag set and is not applied.
- R9: A start-of-field pulse with no prior commit changes nothing. Writes to addresses outside the six offsets change no readback or output.
- R10: Read data appears on bus_rdata one cycle after the read strobe. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| sof | input | 1 | Start-of-field pulse (field boundary) |
| field_active | input | 1 | High while a field is being processed |
| act_width | output | DIM_W | Active output width |
| act_height | output | DIM_W | Active output height |
| act_hbank | output | BANK_W | Active horizontal coefficient read bank |
| act_vbank | output | BANK_W | Active vertical coefficient read bank |

## Verification
The bench builds the block with DIM_W of 12 and BANK_W of 3, and with non-zero defaults of 640, 480, 1 and 2. The narrowed fields make the masking of written bits above each field visible in readback, which the full 16-bit and 4-bit widths would hide. The non-zero defaults make a wrongly applied reset or transfer visible on the outputs. The default registered read path is used. With it, the one-cycle read latency and the sampling of status at the read edge are compared against the reference model on every cycle, through sequences of commits, start-of-field pulses and writes that coincide with them.

// File: rtl/scl_cfg_pkg.sv
package scl_cfg_pkg;
   localparam int BUS_W    = 32;
   localparam int NUM_REGS = 6;

   typedef enum logic [2:0] {
      RI_STATUS = 3'd0,
      RI_COMMIT = 3'd1,
      RI_WIDTH  = 3'd2,
      RI_HEIGHT = 3'd3,
      RI_HBANK  = 3'd4,
      RI_VBANK  = 3'd5,
      RI_NONE   = 3'd7
   } reg_idx_e;
endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode
   import scl_cfg_pkg::*;
#(
   parameter int              ADDR_W = 12,
   parameter logic [ADDR_W-1:0] BASE = 12'h140
)(
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output reg_idx_e          idx,
   output logic              wr_commit,
   output logic              wr_set,
   output logic [3:0]        fld_we
);
   localparam int SPAN = NUM_REGS * 4;

   logic [ADDR_W-1:0] off;

   always_comb begin
      off = bus_addr - BASE;
      if (bus_addr >= BASE && off < ADDR_W'(SPAN) && off[1:0] == 2'b00)
         idx = reg_idx_e'(off[4:2]);
      else
         idx = RI_NONE;
   end

   for (genvar g = 0; g < 4; g++) begin : g_we
      assign fld_we[g] = bus_wr && (idx == reg_idx_e'(3'(int'(RI_WIDTH) + g)));
   end

   assign wr_set    = |fld_we;
   assign wr_commit = bus_wr && (idx == RI_COMMIT);
endmodule

// File: rtl/scl_cfg_shadow.sv
module scl_cfg_shadow #(
   parameter int               DIM_W  = 16,
   parameter int               BANK_W = 4,
   parameter logic [DIM_W-1:0]  DEF_WIDTH  = '0,
   parameter logic [DIM_W-1:0]  DEF_HEIGHT = '0,
   parameter logic [BANK_W-1:0] DEF_HBANK  = '0,
   parameter logic [BANK_W-1:0] DEF_VBANK  = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        fld_we,
   input  logic [DIM_W-1:0]  wdata_dim,
   input  logic [BANK_W-1:0] wdata_bank,
   output logic [DIM_W-1:0]  sh_width,
   output logic [DIM_W-1:0]  sh_height,
   output logic [BANK_W-1:0] sh_hbank,
   output logic [BANK_W-1:0] sh_vbank
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_width  <= DEF_WIDTH;
         sh_height <= DEF_HEIGHT;
         sh_hbank  <= DEF_HBANK;
         sh_vbank  <= DEF_VBANK;
      end else begin
         if (fld_we[0]) sh_width  <= wdata_dim;
         if (fld_we[1]) sh_height <= wdata_dim;
         if (fld_we[2]) sh_hbank  <= wdata_bank;
         if (fld_we[3]) sh_vbank  <= wdata_bank;
      end
   end
endmodule

// File: rtl/scl_cfg_apply.sv
module scl_cfg_apply #(
   parameter int               DIM_W  = 16,
   parameter int               BANK_W = 4,
   parameter logic [DIM_W-1:0]  DEF_WIDTH  = '0,
   parameter logic [DIM_W-1:0]  DEF_HEIGHT = '0,
   parameter logic [BANK_W-1:0] DEF_HBANK  = '0,
   parameter logic [BANK_W-1:0] DEF_VBANK  = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sof,
   input  logic              wr_commit,
   input  logic              wr_set,
   input  logic [DIM_W-1:0]  sh_width,
   input  logic [DIM_W-1:0]  sh_height,
   input  logic [BANK_W-1:0] sh_hbank,
   input  logic [BANK_W-1:0] sh_vbank,
   output logic              pending,
   output logic [DIM_W-1:0]  act_width,
   output logic [DIM_W-1:0]  act_height,
   output logic [BANK_W-1:0] act_hbank,
   output logic [BANK_W-1:0] act_vbank
);
   logic armed;
   logic xfer;

   assign xfer = sof && armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         pending <= 1'b0;
      end else begin
         armed <= wr_commit || (armed && !sof);
         if (wr_set)    pending <= 1'b1;
         else if (xfer) pending <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_width  <= DEF_WIDTH;
         act_height <= DEF_HEIGHT;
         act_hbank  <= DEF_HBANK;
         act_vbank  <= DEF_VBANK;
      end else if (xfer) begin
         act_width  <= sh_width;
         act_height <= sh_height;
         act_hbank  <= sh_hbank;
         act_vbank  <= sh_vbank;
      end
   end

   a_r3_write_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> pending);
   a_r6_boundary_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !wr_set) |=> !pending);
   a_r6_boundary_loads_shadow: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |=> (act_width == $past(sh_width) && act_height == $past(sh_height)
                && act_hbank == $past(sh_hbank) && act_vbank == $past(sh_vbank)));
   a_r7_commit_at_sof_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_commit && sof) |=> armed);
   a_r9_no_commit_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |=> ($stable(act_width) && $stable(act_height)
                  && $stable(act_hbank) && $stable(act_vbank)));
endmodule

// File: rtl/scl_settings_ctrl.sv
module scl_settings_ctrl
   import scl_cfg_pkg::*;
#(
   parameter int               ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] BASE    = 12'h140,
   parameter int               DIM_W    = 16,
   parameter int               BANK_W   = 4,
   parameter bit               RDATA_REG = 1'b1,
   parameter logic [DIM_W-1:0]  DEF_WIDTH  = 16'd1920,
   parameter logic [DIM_W-1:0]  DEF_HEIGHT = 16'd1080,
   parameter logic [BANK_W-1:0] DEF_HBANK  = '0,
   parameter logic [BANK_W-1:0] DEF_VBANK  = '0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              sof,
   input  logic              field_active,
   output logic [DIM_W-1:0]  act_width,
   output logic [DIM_W-1:0]  act_height,
   output logic [BANK_W-1:0] act_hbank,
   output logic [BANK_W-1:0] act_vbank
);
   localparam int DIM_PAD  = BUS_W - DIM_W;
   localparam int BANK_PAD = BUS_W - BANK_W;

   if (DIM_W < 1 || DIM_W > 16) begin : g_bad_dim
      $error("DIM_W must lie in 1..16");
   end
   if (BANK_W < 1 || BANK_W > 4) begin : g_bad_bank
      $error("BANK_W must lie in 1..4");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W too narrow for the register window");
   end

   reg_idx_e          idx;
   logic              wr_commit, wr_set, pending;
   logic [3:0]        fld_we;
   logic [DIM_W-1:0]  sh_width, sh_height;
   logic [BANK_W-1:0] sh_hbank, sh_vbank;
   logic [31:0]       rd_mux;

   scl_cfg_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
      .bus_wr(bus_wr), .bus_addr(bus_addr), .idx(idx),
      .wr_commit(wr_commit), .wr_set(wr_set), .fld_we(fld_we));

   scl_cfg_shadow #(.DIM_W(DIM_W), .BANK_W(BANK_W),
      .DEF_WIDTH(DEF_WIDTH), .DEF_HEIGHT(DEF_HEIGHT),
      .DEF_HBANK(DEF_HBANK), .DEF_VBANK(DEF_VBANK)) u_sh (
      .clk(clk), .rst_n(rst_n), .fld_we(fld_we),
      .wdata_dim(bus_wdata[DIM_W-1:0]), .wdata_bank(bus_wdata[BANK_W-1:0]),
      .sh_width(sh_width), .sh_height(sh_height),
      .sh_hbank(sh_hbank), .sh_vbank(sh_vbank));

   scl_cfg_apply #(.DIM_W(DIM_W), .BANK_W(BANK_W),
      .DEF_WIDTH(DEF_WIDTH), .DEF_HEIGHT(DEF_HEIGHT),
      .DEF_HBANK(DEF_HBANK), .DEF_VBANK(DEF_VBANK)) u_app (
      .clk(clk), .rst_n(rst_n), .sof(sof),
      .wr_commit(wr_commit), .wr_set(wr_set),
      .sh_width(sh_width), .sh_height(sh_height),
      .sh_hbank(sh_hbank), .sh_vbank(sh_vbank),
      .pending(pending),
      .act_width(act_width), .act_height(act_height),
      .act_hbank(act_hbank), .act_vbank(act_vbank));

   always_comb begin
      unique case (idx)
         RI_STATUS: rd_mux = {30'd0, pending, field_active};
         RI_WIDTH:  rd_mux = {{DIM_PAD{1'b0}}, sh_width};
         RI_HEIGHT: rd_mux = {{DIM_PAD{1'b0}}, sh_height};
         RI_HBANK:  rd_mux = {{BANK_PAD{1'b0}}, sh_hbank};
         RI_VBANK:  rd_mux = {{BANK_PAD{1'b0}}, sh_vbank};
         default:   rd_mux = '0;
      endcase
   end

   if (RDATA_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      bus_rdata <= '0;
         else if (bus_rd) bus_rdata <= rd_mux;
      end
      a_r10_rd_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && idx == RI_NONE) |=> (bus_rdata == 32'd0));
      a_r2_status_busy_bit: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && idx == RI_STATUS) |=> (bus_rdata[0] == $past(field_active)));
   end else begin : g_rd_comb
      assign bus_rdata = bus_rd ? rd_mux : '0;
   end
endmodule

// File: tb/sim_scl_settings_ctrl.sv
module sim_scl_settings_ctrl;
   localparam int AW = 12;
   localparam int DW = 12;
   localparam int BW = 3;
   localparam int D_W = 640, D_H = 480, D_HB = 1, D_VB = 2;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          bus_wr = 0, bus_rd = 0, sof = 0, field_active = 0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [DW-1:0] act_width, act_height;
   logic [BW-1:0] act_hbank, act_vbank;

   scl_settings_ctrl #(.ADDR_W(AW), .BASE(12'h140), .DIM_W(DW), .BANK_W(BW),
      .RDATA_REG(1'b1), .DEF_WIDTH(12'(D_W)), .DEF_HEIGHT(12'(D_H)),
      .DEF_HBANK(3'(D_HB)), .DEF_VBANK(3'(D_VB))) u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sof(sof), .field_active(field_active),
      .act_width(act_width), .act_height(act_height),
      .act_hbank(act_hbank), .act_vbank(act_vbank));

   int checks = 0, errors = 0;
   bit done = 0;
   string tag = "R1";

   // behavioural reference
   int m_sh[4];
   int m_act[4];
   bit m_pend, m_arm, m_rv;
   int m_rd;
   int masks[4] = '{'hFFF, 'hFFF, 'h7, 'h7};

   function automatic int slot(int a);
      case (a)
         'h148: return 0;
         'h14C: return 1;
         'h150: return 2;
         'h154: return 3;
         default: return -1;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sh  = '{D_W, D_H, D_HB, D_VB};
         m_act = '{D_W, D_H, D_HB, D_VB};
         m_pend = 0; m_arm = 0; m_rv = 0; m_rd = 0;
      end else begin
         bit xfer, com;
         int s;
         s = slot(int'(bus_addr));
         if (bus_rd) begin
            m_rv = 1;
            if (int'(bus_addr) == 'h140) m_rd = {m_pend, field_active};
            else if (s >= 0) m_rd = m_sh[s];
            else m_rd = 0;
         end else m_rv = 0;
         xfer = sof && m_arm;
         com  = bus_wr && int'(bus_addr) == 'h144;
         if (xfer) m_act = m_sh;
         if (bus_wr && s >= 0) m_pend = 1;
         else if (xfer) m_pend = 0;
         m_arm = com || (m_arm && !sof);
         if (bus_wr && s >= 0) m_sh[s] = int'(bus_wdata) & masks[s];
      end
   end

   task automatic chk(bit ok, string t, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", t, act, exp);
      end
   endtask

   task automatic compare_all();
      chk(int'(act_width) == m_act[0], {tag, " width"}, int'(act_width), m_act[0]);
      chk(int'(act_height) == m_act[1], {tag, " height"}, int'(act_height), m_act[1]);
      chk(int'(act_hbank) == m_act[2], {tag, " hbank"}, int'(act_hbank), m_act[2]);
      chk(int'(act_vbank) == m_act[3], {tag, " vbank"}, int'(act_vbank), m_act[3]);
      if (m_rv) chk(int'(bus_rdata) == m_rd, {tag, " rdata"}, int'(bus_rdata), m_rd);
   endtask

   task automatic cyc(bit wr, bit rd, int addr, int wd, bit s);
      @(negedge clk);
      compare_all();
      bus_wr = wr; bus_rd = rd; bus_addr = AW'(addr); bus_wdata = wd; sof = s;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
   endtask

   task automatic rd_chk(int addr, int exp, string t);
      cyc(0, 1, addr, 0, 0);
      cyc(0, 0, 0, 0, 0);
      chk(int'(bus_rdata) == exp, t, int'(bus_rdata), exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      tag = "R1";
      idle(1);
      chk(act_width == 12'(D_W) && act_vbank == 3'(D_VB), "R1 act defaults",
          int'(act_width), D_W);
      rd_chk('h140, 0, "R1 status");
      rd_chk('h14C, D_H, "R1 shadow height");
      // R2 busy bit
      tag = "R2";
      field_active = 1;
      rd_chk('h140, 1, "R2 status busy");
      field_active = 0;
      // R3 / R4 writes, masking, pending
      tag = "R4";
      cyc(1, 0, 'h148, 'hFF123, 0);
      rd_chk('h148, 'h123, "R4 width masked");
      rd_chk('h140, 2, "R3 pending set");
      cyc(1, 0, 'h150, 'hFF, 0);
      rd_chk('h150, 7, "R4 bank masked");
      // R9 sof without commit, unmapped writes
      tag = "R9";
      cyc(0, 0, 0, 0, 1); idle(2);
      chk(int'(act_width) == D_W, "R9 sof no commit", int'(act_width), D_W);
      cyc(1, 0, 'h158, 'h55, 0);
      cyc(1, 0, 'h14A, 'h55, 0);
      rd_chk('h158, 0, "R10 unmapped read");
      rd_chk('h148, 'h123, "R9 unmapped write ignored");
      // R5 commit, data ignored, no change before boundary
      tag = "R5";
      cyc(1, 0, 'h144, 'hDEADBEEF, 0); idle(3);
      chk(int'(act_width) == D_W, "R5 held before boundary", int'(act_width), D_W);
      rd_chk('h144, 0, "R5 commit reads zero");
      // R6 boundary applies
      tag = "R6";
      cyc(0, 0, 0, 0, 1); idle(1);
      chk(int'(act_width) == 'h123 && int'(act_hbank) == 7, "R6 applied",
          int'(act_width), 'h123);
      rd_chk('h140, 0, "R6 pending cleared");
      // R8 write after commit joins update
      tag = "R8";
      cyc(1, 0, 'h14C, 720, 0);
      cyc(1, 0, 'h144, 0, 0);
      cyc(1, 0, 'h154, 5, 0);
      cyc(0, 0, 0, 0, 1); idle(1);
      chk(int'(act_height) == 720 && int'(act_vbank) == 5, "R8 late write applied",
          int'(act_vbank), 5);
      // R8 write coinciding with applying sof keeps pending
      cyc(1, 0, 'h144, 0, 0);
      cyc(1, 0, 'h148, 'h200, 1); idle(1);
      chk(int'(act_width) == 'h123, "R8 same-cycle write not applied",
          int'(act_width), 'h123);
      rd_chk('h140, 2, "R8 pending kept");
      // R7 commit with sof
      tag = "R7";
      cyc(1, 0, 'h144, 0, 1); idle(2);
      chk(int'(act_width) == 'h123, "R7 not at same sof", int'(act_width), 'h123);
      field_active = 1;
      cyc(0, 0, 0, 0, 1); idle(1);
      chk(int'(act_width) == 'h200, "R7 applied next sof", int'(act_width), 'h200);
      rd_chk('h140, 1, "R7 status after apply");
      field_active = 0;
      idle(3);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule